// File: doc/BRIEF.md
# Serial DAC Front-End Controller

This block is the digital front end of a single-channel voltage-output DAC. A host sends 16-bit words over a three-wire serial port made of an active-low frame select, a serial clock and a data line. Each word carries a two-bit output-stage selector and a 12-bit or 14-bit conversion code. The block drives a code register, an output-stage mode and a one-cycle update strobe toward the analog section.

The three serial pins are brought into the system clock domain through a synchronizer. Falling edges of the serial clock are then detected in that domain, so the serial clock must be several times slower than the system clock. A word takes effect only if the frame select stays low through the sixteenth falling edge. Raising the frame select earlier throws the partial word away.

A parameter picks whether reset loads a zero code or a midscale code. Another parameter picks the code width, which sets where the code sits inside the word.

Top module: `serdac_frontend`

## Requirements
- R1: After a high-to-low transition of `frm_n`, `sdin` is sampled on each falling edge of `sclk`. The first bit sampled is word bit 15 and the sixteenth bit sampled is word bit 0.
- R2: Word bits 15:14 set the output stage, and `out_mode` takes the same value: 0 drives normally, 1 is a 1 kΩ pulldown, 2 is a 100 kΩ pulldown, 3 is open (three-state).
- R3: With `CODE_W`=12, the code is taken from word bits 13:2 and word bits 1:0 have no effect. With `CODE_W`=14, the code is taken from word bits 13:0.
- R4: On the sixteenth falling edge, `dac_code` and `out_mode` change in the same cycle. `upd_pulse` is high for exactly that one cycle. Neither output changes in any other cycle.
- R5: If `frm_n` rises before the sixteenth falling edge, the partial word is cleared. `dac_code`, `out_mode` and `upd_pulse` stay unchanged, and the next full frame is accepted normally.
- R6: Falling edges of `sclk` after the sixteenth, while `frm_n` is still low, are ignored. A new frame starts only after `frm_n` goes high and then low again.
- R7: A word whose bits 15:14 are nonzero updates `out_mode` and leaves `dac_code` unchanged. A word with bits 15:14 equal to 0 loads both the code and the mode.
- R8: During and after reset, `out_mode` is 0 and `upd_pulse` is 0. `dac_code` is 0 when `RESET_MID`=0 and is 2^(CODE_W-1) when `RESET_MID`=1. These values hold, even if `sclk` toggles while `frm_n` stays high, until a valid frame arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all logic is clocked on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_n | input | 1 | Active-low frame select from the serial host |
| sclk | input | 1 | Serial clock; data is sampled on its falling edges |
| sdin | input | 1 | Serial data, most significant bit first |
| dac_code | output | CODE_W | Code register driving the converter |
| out_mode | output | 2 | Output-stage selection (0 normal, 1 1k, 2 100k, 3 open) |
| upd_pulse | output | 1 | One-cycle strobe when a valid word is applied |

## Verification
The bench builds two copies of the block that share the same serial inputs. One copy has `CODE_W`=12 with a zero reset code, and the other has `CODE_W`=14 with a midscale reset code. Because both copies see every word, each test checks the 12-bit field placement (including the ignored low bits) and the 14-bit field placement at the same time. The second copy also checks the midscale reset value, which a single zero-reset build could never show. Aborts after 10 and after 15 bits, extra clocks after a complete word, and all four output-stage codes are checked on both copies.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
   typedef enum logic [1:0] {
      OSTAGE_DRIVE = 2'b00,
      OSTAGE_1K    = 2'b01,
      OSTAGE_100K  = 2'b10,
      OSTAGE_OPEN  = 2'b11
   } ostage_t;

   localparam int unsigned WORD_BITS = 16;
   localparam int unsigned MODE_BITS = 2;
endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("serdac_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= {STAGES{RST_VAL}};
      end else begin
         pipe[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            pipe[s] <= pipe[s-1];
         end
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/serdac_shifter.sv
module serdac_shifter #(
   parameter int unsigned FRAME_W = 16,
   localparam int unsigned CNT_W  = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frm_n_s,
   input  logic               sclk_s,
   input  logic               sdin_s,
   output logic               commit,
   output logic [FRAME_W-1:0] word,
   output logic [CNT_W-1:0]   bit_cnt
);
   logic               sclk_q;
   logic               frm_q;
   logic               active;
   logic [FRAME_W-1:0] shreg;
   logic               sclk_fall;
   logic               frm_fall;
   logic               take;

   // A frame opens on a select fall and closes at its last bit or on select rise
   assign sclk_fall = sclk_q & ~sclk_s;
   assign frm_fall  = frm_q & ~frm_n_s;
   assign take      = ~frm_n_s & (active | frm_fall) & sclk_fall;
   assign word      = {shreg[FRAME_W-2:0], sdin_s};
   assign commit    = take && (bit_cnt == CNT_W'(FRAME_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q  <= 1'b1;
         frm_q   <= 1'b1;
         active  <= 1'b0;
         bit_cnt <= '0;
         shreg   <= '0;
      end else begin
         sclk_q <= sclk_s;
         frm_q  <= frm_n_s;
         if (frm_n_s) begin
            active  <= 1'b0;
            bit_cnt <= '0;
            shreg   <= '0;
         end else begin
            if (frm_fall) begin
               active  <= 1'b1;
               bit_cnt <= '0;
               shreg   <= '0;
            end
            if (take) begin
               shreg   <= word;
               bit_cnt <= bit_cnt + 1'b1;
               if (commit) begin
                  active <= 1'b0;
               end
            end
         end
      end
   end
endmodule

// File: rtl/serdac_regs.sv
module serdac_regs
   import serdac_pkg::*;
#(
   parameter int unsigned FRAME_W   = 16,
   parameter int unsigned CODE_W    = 12,
   parameter bit          RESET_MID = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               commit,
   input  logic [FRAME_W-1:0] word,
   output logic [CODE_W-1:0]  code,
   output ostage_t            mode,
   output logic               upd
);
   localparam int unsigned CODE_TOP = FRAME_W - MODE_BITS - 1;

   logic [CODE_W-1:0] rst_code;
   logic [CODE_W-1:0] code_field;
   ostage_t           mode_field;

   if (RESET_MID) begin : g_rst_mid
      assign rst_code = {1'b1, {(CODE_W-1){1'b0}}};
   end else begin : g_rst_zero
      assign rst_code = '0;
   end

   // Code is left-justified just below the mode field; unused low bits are dropped
   assign code_field = word[CODE_TOP -: CODE_W];
   assign mode_field = ostage_t'(word[FRAME_W-1 -: MODE_BITS]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= rst_code;
         mode <= OSTAGE_DRIVE;
         upd  <= 1'b0;
      end else begin
         upd <= commit;
         if (commit) begin
            mode <= mode_field;
            if (mode_field == OSTAGE_DRIVE) begin
               code <= code_field;
            end
         end
      end
   end
endmodule

// File: rtl/serdac_frontend.sv
module serdac_frontend
   import serdac_pkg::*;
#(
   parameter int unsigned CODE_W      = 12,
   parameter bit          RESET_MID   = 1'b0,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned FRAME_W    = WORD_BITS,
   localparam int unsigned CNT_W      = $clog2(FRAME_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_n,
   input  logic              sclk,
   input  logic              sdin,
   output logic [CODE_W-1:0] dac_code,
   output logic [1:0]        out_mode,
   output logic              upd_pulse
);
   if (CODE_W < 1 || CODE_W > FRAME_W - MODE_BITS) begin : g_bad_width
      $error("serdac_frontend: CODE_W does not fit beside the mode field");
   end

   logic               frm_s;
   logic               sclk_s;
   logic               sdin_s;
   logic               commit;
   logic [FRAME_W-1:0] word;
   logic [CNT_W-1:0]   bit_cnt;
   ostage_t            mode_q;

   serdac_sync #(
      .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)
   ) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({frm_n, sclk, sdin}),
      .q({frm_s, sclk_s, sdin_s})
   );

   serdac_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .frm_n_s(frm_s), .sclk_s(sclk_s), .sdin_s(sdin_s),
      .commit(commit), .word(word), .bit_cnt(bit_cnt)
   );

   serdac_regs #(
      .FRAME_W(FRAME_W), .CODE_W(CODE_W), .RESET_MID(RESET_MID)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .commit(commit), .word(word),
      .code(dac_code), .mode(mode_q), .upd(upd_pulse)
   );

   assign out_mode = mode_q;
endmodule

// File: rtl/serdac_chk.sv
module serdac_chk #(
   parameter int unsigned FRAME_W = 16,
   parameter int unsigned CODE_W  = 12,
   parameter int unsigned CNT_W   = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frm_s,
   input logic [CNT_W-1:0]  bit_cnt,
   input logic              commit,
   input logic [CODE_W-1:0] dac_code,
   input logic [1:0]        out_mode,
   input logic              upd_pulse
);
   // R1
   bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(FRAME_W));

   // R5
   abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_s |=> (bit_cnt == '0));

   // R4
   upd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> upd_pulse);

   // R4
   upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_pulse |=> !upd_pulse);

   // R4
   code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_pulse |-> $stable(dac_code));

   // R4
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_pulse |-> $stable(out_mode));

   // R7
   pd_code_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_pulse && out_mode != 2'b00) |-> $stable(dac_code));
endmodule

bind serdac_frontend serdac_chk #(
   .FRAME_W(FRAME_W), .CODE_W(CODE_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frm_s(frm_s), .bit_cnt(bit_cnt),
   .commit(commit), .dac_code(dac_code), .out_mode(out_mode),
   .upd_pulse(upd_pulse)
);

// File: tb/sim_serdac_frontend.sv
module sim_serdac_frontend;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frm_n = 1'b1;
   logic sclk = 1'b1;
   logic sdin = 1'b0;

   logic [11:0] code0;
   logic [1:0]  mode0;
   logic        upd0;
   logic [13:0] code1;
   logic [1:0]  mode1;
   logic        upd1;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   int pulses0 = 0;
   int pulses1 = 0;
   logic [11:0] cap_code0 = '0;
   logic [1:0]  cap_mode0 = '0;

   logic [11:0] exp0;
   logic [13:0] exp1;
   logic [1:0]  expm;

   always #5 clk = ~clk;

   serdac_frontend #(.CODE_W(12), .RESET_MID(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .frm_n(frm_n), .sclk(sclk), .sdin(sdin),
      .dac_code(code0), .out_mode(mode0), .upd_pulse(upd0)
   );

   serdac_frontend #(.CODE_W(14), .RESET_MID(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .frm_n(frm_n), .sclk(sclk), .sdin(sdin),
      .dac_code(code1), .out_mode(mode1), .upd_pulse(upd1)
   );

   always @(negedge clk) begin
      if (upd0) begin
         pulses0++;
         cap_code0 = code0;
         cap_mode0 = mode0;
      end
      if (upd1) pulses1++;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] mk(input logic [1:0] m, input logic [11:0] c, input logic [1:0] dc);
      return {m, c, dc};
   endfunction

   task automatic apply_valid(input logic [15:0] w);
      expm = w[15:14];
      if (w[15:14] == 2'b00) begin
         exp0 = w[13:2];
         exp1 = w[13:0];
      end
   endtask

   task automatic check_state(input string req);
      chk({req, " code12"}, 32'(code0), 32'(exp0));
      chk({req, " code14"}, 32'(code1), 32'(exp1));
      chk({req, " mode12"}, 32'(mode0), 32'(expm));
      chk({req, " mode14"}, 32'(mode1), 32'(expm));
   endtask

   task automatic shift_bits(input logic [15:0] w, input int n);
      for (int i = 0; i < n; i++) begin
         sdin = w[15-i];
         tick(4);
         sclk = 1'b0;
         tick(4);
         sclk = 1'b1;
      end
   endtask

   task automatic send(input logic [15:0] w, input int n);
      frm_n = 1'b0;
      tick(4);
      shift_bits(w, n);
      tick(2);
      frm_n = 1'b1;
      tick(8);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      tick(5);
      chk("R8 reset code12", 32'(code0), 32'h0);
      chk("R8 reset code14 midscale", 32'(code1), 32'h2000);
      chk("R8 reset mode", 32'(mode0), 32'h0);
      chk("R8 reset upd", 32'(upd0), 32'h0);
      rst_n = 1'b1;
      tick(5);
      exp0 = 12'h000;
      exp1 = 14'h2000;
      expm = 2'b00;
      check_state("R8 after release");
   endtask

   task automatic t_idle_clocks;
      for (int i = 0; i < 20; i++) begin
         sdin = i[0];
         tick(3);
         sclk = 1'b0;
         tick(3);
         sclk = 1'b1;
      end
      tick(6);
      check_state("R8 hold idle clocks");
      chk("R8 no pulse idle", 32'(pulses0 + pulses1), 32'h0);
   endtask

   task automatic t_frame(input logic [15:0] w, input string req);
      int p0 = pulses0;
      int p1 = pulses1;
      send(w, 16);
      apply_valid(w);
      check_state(req);
      chk({req, " R4 one pulse12"}, 32'(pulses0 - p0), 32'h1);
      chk({req, " R4 one pulse14"}, 32'(pulses1 - p1), 32'h1);
      chk({req, " R4 code at pulse"}, 32'(cap_code0), 32'(exp0));
      chk({req, " R4 mode at pulse"}, 32'(cap_mode0), 32'(expm));
   endtask

   task automatic t_abort(input int n);
      int p0 = pulses0;
      send(mk(2'b11, 12'h5AA, 2'b10), n);
      check_state($sformatf("R5 abort after %0d", n));
      chk("R5 no pulse on abort", 32'(pulses0 - p0), 32'h0);
   endtask

   task automatic t_extra;
      int p0 = pulses0;
      logic [15:0] w1 = mk(2'b00, 12'h123, 2'b00);
      logic [15:0] w2 = mk(2'b10, 12'hFED, 2'b11);
      frm_n = 1'b0;
      tick(4);
      shift_bits(w1, 16);
      shift_bits(w2, 16);
      tick(2);
      frm_n = 1'b1;
      tick(8);
      apply_valid(w1);
      check_state("R6 extra clocks ignored");
      chk("R6 single pulse", 32'(pulses0 - p0), 32'h1);
   endtask

   task automatic t_powerdown;
      t_frame(mk(2'b01, 12'h111, 2'b00), "R7 R2 mode 1k");
      t_frame(mk(2'b10, 12'h222, 2'b01), "R7 R2 mode 100k");
      t_frame(mk(2'b11, 12'h333, 2'b10), "R7 R2 mode open");
      t_frame(mk(2'b00, 12'h3C3, 2'b01), "R7 R2 back to normal");
   endtask

   initial begin
      t_reset();
      t_idle_clocks();
      t_frame(mk(2'b00, 12'hABC, 2'b11), "R1 R3 basic");
      t_frame(mk(2'b00, 12'h801, 2'b00), "R1 bit order");
      t_frame(mk(2'b00, 12'h7FE, 2'b10), "R3 low bits");
      t_abort(10);
      t_abort(15);
      t_frame(mk(2'b00, 12'h5A5, 2'b01), "R5 recover");
      t_extra();
      t_powerdown();
      t_frame(mk(2'b00, 12'hFFF, 2'b11), "R3 full scale");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule